// File: doc/BRIEF.md
# Half-Step Pre-Divider with Fractional M/N Clock-Enable Generator

This block turns a fast reference clock into a train of single-cycle clock-enable pulses at a programmable lower rate. The reference clock runs at twice the rate of the source clock being divided, so every reference cycle is one half-period of the source. The divider therefore works in half steps. The first stage is a pre-divider that emits one pulse every `pdiv+1` reference cycles. A field of zero gives no division: one pulse every two reference cycles, which is the source rate.

The second stage is an optional fractional stage. On every pre-divider pulse it adds `m` to an accumulator, modulo `n`, and passes a pulse on each wrap. Over any `n` input pulses this yields exactly `m` output pulses. While the fractional stage is active, a level output is high whenever the accumulator is below a programmed duty threshold. The divisor and duty values arrive in the same bit-inverted encodings that configuration software writes.

Configuration inputs are captured only on a load strobe. A load restarts both stages from zero, so a reprogramming never produces a shortened pulse.

Top module: `halfstep_mn_clkgen`

## Requirements
- R1: During reset and in the first cycle after the first clock edge with reset low, `clk_en_o` and `duty_lvl_o` are 0. Reset selects pre-field 0 with the fractional stage off, so `clk_en_o` is first high in the cycle after the second edge with reset low.
- R2: With pre-field 0 and the fractional stage inactive, `clk_en_o` pulses once every 2 cycles.
- R3: With a nonzero pre-field `p` and the fractional stage inactive, `clk_en_o` pulses once every `p+1` cycles. This gives a rate of 2/(p+1) of the source rate.
- R4: Let P be the pre-divider period. If `load_i` is high in cycle c, `clk_en_o` is low in cycles c+1 through c+P, is first high in cycle c+P+1, and then repeats every P cycles.
- R5: Changes on `pdiv_i`, `mode_i`, `m_i`, `n_i` and `d_i` while `load_i` is low have no effect on either output.
- R6: The block decodes its loaded values with all arithmetic masked to the M/N width: `m` is `m_i`, `n` is `(~n_i) + m`, and the duty threshold is `~d_i`. Software writes `n_i = ~(n-m)` and `d_i = ~duty`.
- R7: The fractional stage is active only when the 2-bit mode is nonzero (1 and 2 both select it; 2 is the dual-edge setting), `m` is nonzero and `m < n`. Otherwise every pre-divider pulse passes straight to `clk_en_o`, and `duty_lvl_o` stays 0.
- R8: When the fractional stage is active, the k-th pre-divider pulse after a load yields a `clk_en_o` pulse exactly when floor(k·m/n) > floor((k−1)·m/n).
- R9: When the fractional stage is active, `duty_lvl_o` is high exactly while (k·m mod n) < duty. Here k is the number of pre-divider pulses already absorbed since the load.
- R10: A load strobe in the same cycle as a due pre-divider pulse takes priority. `clk_en_o` is low in the following cycle and the new sequence starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, twice the source rate |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Captures configuration and restarts both stages |
| pdiv_i | input | PDIV_W | Half-step pre-divide field |
| mode_i | input | 2 | Fractional stage mode, nonzero enables |
| m_i | input | MND_W | Numerator m |
| n_i | input | MND_W | Inverted n−m |
| d_i | input | MND_W | Inverted duty threshold |
| clk_en_o | output | 1 | Single-cycle clock-enable pulse |
| duty_lvl_o | output | 1 | Duty-controlled level of the fractional stage |

## Verification
A load strobe and a pulse that the pre-divider has due can land in the same cycle, and only one of them may win. The bench provokes this clash by reprogramming from a period-3 setting exactly in the cycle where the pre-divider counter sits at its last count. It judges the outcome by requiring `clk_en_o` to stay low in the next cycle and the fresh period-2 sequence to appear two cycles later. Every table vector is also compared cycle by cycle against a closed-form model of pulse positions and duty level, counted from the load.

// File: rtl/halfstep_mn_pkg.sv
package halfstep_mn_pkg;

    typedef enum logic [1:0] {
        MD_OFF  = 2'd0,
        MD_ONE  = 2'd1,
        MD_DUAL = 2'd2,
        MD_RSVD = 2'd3
    } mnd_mode_e;

    // Any nonzero mode requests the fractional stage.
    function automatic logic mode_requests_mnd(input mnd_mode_e md);
        return md != MD_OFF;
    endfunction

endpackage

// File: rtl/cfg_shadow.sv
module cfg_shadow
    import halfstep_mn_pkg::*;
#(
    parameter int PDIV_W = 5,
    parameter int MND_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [PDIV_W-1:0] pdiv_i,
    input  logic [1:0]        mode_i,
    input  logic [MND_W-1:0]  m_i,
    input  logic [MND_W-1:0]  n_i,
    input  logic [MND_W-1:0]  d_i,
    output logic [PDIV_W:0]   period_o,
    output logic [MND_W-1:0]  m_o,
    output logic [MND_W-1:0]  n_o,
    output logic [MND_W-1:0]  duty_o,
    output logic              active_o
);
    localparam logic [PDIV_W:0] PER_ONE = {{PDIV_W{1'b0}}, 1'b1};
    localparam logic [PDIV_W:0] PER_TWO = PER_ONE + PER_ONE;

    logic [PDIV_W-1:0] pdiv_q;
    mnd_mode_e         mode_q;
    logic [MND_W-1:0]  m_q;
    logic [MND_W-1:0]  ninv_q;
    logic [MND_W-1:0]  dinv_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pdiv_q <= '0;
            mode_q <= MD_OFF;
            m_q    <= '0;
            ninv_q <= '0;
            dinv_q <= '0;
        end else if (load_i) begin
            pdiv_q <= pdiv_i;
            mode_q <= mnd_mode_e'(mode_i);
            m_q    <= m_i;
            ninv_q <= n_i;
            dinv_q <= d_i;
        end
    end

    always_comb begin
        period_o = (pdiv_q == '0) ? PER_TWO : ({1'b0, pdiv_q} + PER_ONE);
        m_o      = m_q;
        n_o      = (~ninv_q) + m_q;
        duty_o   = ~dinv_q;
        active_o = mode_requests_mnd(mode_q) && (m_q != '0) && (m_q < n_o);
    end

endmodule

// File: rtl/halfstep_prediv.sv
module halfstep_prediv #(
    parameter int PDIV_W = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            restart_i,
    input  logic [PDIV_W:0] period_i,
    output logic            tick_o
);
    localparam logic [PDIV_W:0] CNT_ONE = {{PDIV_W{1'b0}}, 1'b1};

    logic [PDIV_W:0] cnt_q;
    logic [PDIV_W:0] last_cnt;

    assign last_cnt = period_i - CNT_ONE;
    assign tick_o   = (cnt_q == last_cnt);

    always_ff @(posedge clk) begin
        if (rst || restart_i) begin
            cnt_q <= '0;
        end else if (tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_ONE;
        end
    end

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        !restart_i |=> (cnt_q < period_i));

endmodule

// File: rtl/mn_accum.sv
module mn_accum #(
    parameter int MND_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart_i,
    input  logic             tick_i,
    input  logic             active_i,
    input  logic [MND_W-1:0] m_i,
    input  logic [MND_W-1:0] n_i,
    input  logic [MND_W-1:0] duty_i,
    output logic             out_en_o,
    output logic             level_o
);
    logic [MND_W-1:0] acc_q;
    logic [MND_W:0]   sum;
    logic             wrap;
    logic [MND_W:0]   folded;

    assign sum    = {1'b0, acc_q} + {1'b0, m_i};
    assign wrap   = sum >= {1'b0, n_i};
    assign folded = sum - {1'b0, n_i};

    always_ff @(posedge clk) begin
        if (rst || restart_i) begin
            acc_q    <= '0;
            out_en_o <= 1'b0;
        end else if (tick_i) begin
            if (active_i) begin
                acc_q    <= wrap ? folded[MND_W-1:0] : sum[MND_W-1:0];
                out_en_o <= wrap;
            end else begin
                acc_q    <= '0;
                out_en_o <= 1'b1;
            end
        end else begin
            out_en_o <= 1'b0;
        end
    end

    assign level_o = active_i && (acc_q < duty_i);

    // R8
    acc_range_chk: assert property (@(posedge clk) disable iff (rst)
        active_i |-> (acc_q < n_i));

    // R10
    out_en_src_chk: assert property (@(posedge clk) disable iff (rst)
        out_en_o |-> $past(tick_i && !restart_i));

endmodule

// File: rtl/halfstep_mn_clkgen.sv
module halfstep_mn_clkgen #(
    parameter int PDIV_W = 5,
    parameter int MND_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [PDIV_W-1:0] pdiv_i,
    input  logic [1:0]        mode_i,
    input  logic [MND_W-1:0]  m_i,
    input  logic [MND_W-1:0]  n_i,
    input  logic [MND_W-1:0]  d_i,
    output logic              clk_en_o,
    output logic              duty_lvl_o
);
    logic [PDIV_W:0]  period;
    logic [MND_W-1:0] m_dec;
    logic [MND_W-1:0] n_dec;
    logic [MND_W-1:0] duty_dec;
    logic             active;
    logic             tick;

    cfg_shadow #(.PDIV_W(PDIV_W), .MND_W(MND_W)) shadow_u (
        .clk      (clk),
        .rst      (rst),
        .load_i   (load_i),
        .pdiv_i   (pdiv_i),
        .mode_i   (mode_i),
        .m_i      (m_i),
        .n_i      (n_i),
        .d_i      (d_i),
        .period_o (period),
        .m_o      (m_dec),
        .n_o      (n_dec),
        .duty_o   (duty_dec),
        .active_o (active)
    );

    halfstep_prediv #(.PDIV_W(PDIV_W)) prediv_u (
        .clk       (clk),
        .rst       (rst),
        .restart_i (load_i),
        .period_i  (period),
        .tick_o    (tick)
    );

    mn_accum #(.MND_W(MND_W)) accum_u (
        .clk       (clk),
        .rst       (rst),
        .restart_i (load_i),
        .tick_i    (tick),
        .active_i  (active),
        .m_i       (m_dec),
        .n_i       (n_dec),
        .duty_i    (duty_dec),
        .out_en_o  (clk_en_o),
        .level_o   (duty_lvl_o)
    );

    // R4
    load_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |=> !clk_en_o);

    // R7
    bypass_level_chk: assert property (@(posedge clk) disable iff (rst)
        !active |-> !duty_lvl_o);

endmodule

// File: tb/halfstep_mn_clkgen_tb_top.sv
`timescale 1ns/1ps
module halfstep_mn_clkgen_tb_top;

    localparam int PDIV_W = 5;
    localparam int MND_W  = 8;
    localparam int WIN    = 120;
    localparam int NV     = 10;

    // {pdiv, mode, m, n, duty, expected pulse count in WIN cycles}
    localparam logic [47:0] VEC [NV] = '{
        {8'd0,  8'd0, 8'd0, 8'd0, 8'd0, 8'd59},  // R2
        {8'd1,  8'd0, 8'd0, 8'd0, 8'd0, 8'd59},  // R3
        {8'd2,  8'd0, 8'd0, 8'd0, 8'd0, 8'd39},  // R3
        {8'd3,  8'd0, 8'd0, 8'd0, 8'd0, 8'd29},  // R3
        {8'd4,  8'd2, 8'd1, 8'd3, 8'd1, 8'd7},   // R8
        {8'd0,  8'd2, 8'd3, 8'd8, 8'd4, 8'd22},  // R8
        {8'd0,  8'd2, 8'd5, 8'd5, 8'd0, 8'd59},  // R7 m==n
        {8'd2,  8'd0, 8'd1, 8'd4, 8'd2, 8'd39},  // R7 mode 0
        {8'd5,  8'd1, 8'd2, 8'd7, 8'd3, 8'd5},   // R8 mode 1
        {8'd31, 8'd0, 8'd0, 8'd0, 8'd0, 8'd3}    // R3 max field
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              load_i = 1'b0;
    logic [PDIV_W-1:0] pdiv_i = '0;
    logic [1:0]        mode_i = '0;
    logic [MND_W-1:0]  m_i = '0;
    logic [MND_W-1:0]  n_i = '0;
    logic [MND_W-1:0]  d_i = '0;
    logic              clk_en_o;
    logic              duty_lvl_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    halfstep_mn_clkgen #(.PDIV_W(PDIV_W), .MND_W(MND_W)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .load_i     (load_i),
        .pdiv_i     (pdiv_i),
        .mode_i     (mode_i),
        .m_i        (m_i),
        .n_i        (n_i),
        .d_i        (d_i),
        .clk_en_o   (clk_en_o),
        .duty_lvl_o (duty_lvl_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drives a configuration with load high for one cycle; returns in cycle t=0.
    task automatic apply_load(input int p, input int md, input int m, input int n, input int duty);
        @(negedge clk);
        pdiv_i = PDIV_W'(p);
        mode_i = 2'(md);
        m_i    = MND_W'(m);
        n_i    = ~MND_W'(n - m);
        d_i    = ~MND_W'(duty);
        load_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0;
    endtask

    task automatic run_vec(input int idx);
        int p, md, m, n, duty, expc, per, cnt, bad_en, bad_lv;
        bit act;
        p    = int'(VEC[idx][47:40]);
        md   = int'(VEC[idx][39:32]);
        m    = int'(VEC[idx][31:24]);
        n    = int'(VEC[idx][23:16]);
        duty = int'(VEC[idx][15:8]);
        expc = int'(VEC[idx][7:0]);
        per  = (p == 0) ? 2 : p + 1;
        act  = (md != 0) && (m != 0) && (m < n);
        cnt = 0; bad_en = 0; bad_lv = 0;
        apply_load(p, md, m, n, duty);
        for (int t = 0; t < WIN; t++) begin
            int k;
            bit exp_en, exp_lv;
            if (t > 0) @(negedge clk);
            k = t / per;
            exp_en = (t >= per) && (t % per == 0) &&
                     (!act || ((k * m) / n > ((k - 1) * m) / n));
            exp_lv = act && (((k * m) % n) < duty);
            if (clk_en_o) cnt++;
            if (clk_en_o !== exp_en) bad_en++;
            if (duty_lvl_o !== exp_lv) bad_lv++;
            if (t == 0) begin
                // R5: scramble inputs without load
                pdiv_i = 5'd7; mode_i = 2'd3; m_i = 8'd9; n_i = 8'h12; d_i = 8'h34;
            end
        end
        check(cnt == expc, $sformatf("R3/R8/R5 vec%0d pulse count", idx), cnt, expc);
        check(bad_en == 0, $sformatf("R4/R7/R8 vec%0d clk_en cycle mismatches", idx), bad_en, 0);
        check(bad_lv == 0, $sformatf("R9/R6 vec%0d level cycle mismatches", idx), bad_lv, 0);
    endtask

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        check(clk_en_o == 1'b0, "R1 clk_en in reset", int'(clk_en_o), 0);
        check(duty_lvl_o == 1'b0, "R1 level in reset", int'(duty_lvl_o), 0);
        rst = 1'b0;
        @(negedge clk);
        check(clk_en_o == 1'b0, "R1 clk_en after first edge", int'(clk_en_o), 0);
        @(negedge clk);
        check(clk_en_o == 1'b1, "R1 default bypass first pulse", int'(clk_en_o), 1);

        for (int i = 0; i < NV; i++) run_vec(i);

        // R10: load colliding with a due pre-divider pulse
        apply_load(2, 0, 0, 0, 0);
        @(negedge clk);
        @(negedge clk);
        pdiv_i = '0; mode_i = '0; m_i = '0; n_i = '0; d_i = '0;
        load_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0;
        check(clk_en_o == 1'b0, "R10 load wins over due pulse", int'(clk_en_o), 0);
        @(negedge clk);
        check(clk_en_o == 1'b0, "R10 restart t=1", int'(clk_en_o), 0);
        @(negedge clk);
        check(clk_en_o == 1'b1, "R10 restart first pulse at t=2", int'(clk_en_o), 1);
        check(duty_lvl_o == 1'b0, "R7 level low in bypass", int'(duty_lvl_o), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule